// File: doc/BRIEF.md
# Start/End Marker Packet Framer

This block sits behind a serial read controller that pulls bytes off a link which pads idle time with zero fill. It watches the incoming byte stream for a start marker (0xFF), stores the marker and every byte that follows in an internal packet store, and stops collecting when it sees an end marker (0xFE). Only then is the whole packet, markers included, released on a streaming output with valid, ready and last. While a packet is being released, the input is held off through a ready signal.

A start marker that arrives before the end marker throws away the partial packet, and collection begins again at the new marker. A packet longer than the store is thrown away too, and the framer goes back to hunting. Both cases advance a saturating drop counter. The `in_packet_o` flag tells the read controller that a packet is open, so it can keep chip select asserted until the packet is complete.

Top module: `pkt_framer`

## Requirements
- R1: During and after reset, `out_valid_o` is 0, `in_packet_o` is 0, `drop_cnt_o` is 0 and `in_ready_o` is 1.
- R2: While hunting, every accepted byte other than 0xFF is discarded: no output, `in_packet_o` stays 0 and `drop_cnt_o` is unchanged.
- R3: An accepted 0xFF while hunting opens a packet, and `in_packet_o` is 1 from the next cycle on.
- R4: An accepted 0xFE while collecting closes the packet. From the next cycle the packet is output in arrival order, starting with 0xFF and ending with 0xFE, and `out_last_o` is 1 only on the 0xFE byte.
- R5: `out_valid_o` is never 1 before the end marker of a packet has been accepted, so partial packets never reach the output.
- R6: An accepted 0xFF while collecting drops the partial packet, adds one to `drop_cnt_o` and starts a new packet whose first byte is that 0xFF. `in_packet_o` stays 1.
- R7: A packet of exactly DEPTH bytes, markers included, is released. A byte accepted while DEPTH bytes are already stored drops the packet, adds one to `drop_cnt_o` and returns the block to hunting, so `in_packet_o` is 0 from the next cycle.
- R8: While `out_valid_o` is 1, `in_ready_o` is 0. An output byte not taken (`out_ready_i` is 0) stays on `out_data_o` with `out_valid_o` and `out_last_o` unchanged.
- R9: `drop_cnt_o` changes by exactly +1 per drop and saturates at its maximum.
- R10: `in_packet_o` is 1 exactly while a packet is being collected, and 0 while hunting or releasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when high |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the packet |
| out_ready_i | input | 1 | Downstream takes the output byte |
| in_packet_o | output | 1 | A packet is being collected |
| drop_cnt_o | output | CNT_W | Count of dropped packets, saturating |

## Verification
The stream is driven with zero fill and stray end markers before any start, with clean packets of several lengths including the two-byte minimum, and with back-to-back packets that have no filler between them. These patterns separate correct hunting from false triggering. A restart in the middle of a packet checks that only the tail after the second start marker comes out. Packets of exactly DEPTH bytes and of DEPTH+1 bytes pin the length guard to the right byte. Irregular and long-stalled `out_ready_i` shows whether output data holds steady and input is held off during release.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_COLL = 2'd1,
    ST_REL  = 2'd2
  } frm_state_e;
endpackage

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int DEPTH  = 512,
  parameter int DW     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import pkt_framer_pkg::*;
#(
  parameter int          DEPTH = 512,
  parameter logic [7:0]  SOF   = 8'hFF,
  parameter logic [7:0]  EOF   = 8'hFE,
  localparam int         AW    = $clog2(DEPTH),
  localparam int         LW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic          out_last_o,
  input  logic          out_ready_i,
  output logic          in_packet_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          drop_o
);
  localparam logic [LW-1:0] LEN_MAX = LW'(DEPTH);

  frm_state_e    state_q, state_d;
  logic [LW-1:0] len_q, len_d;
  logic [AW-1:0] rd_q, rd_d;
  logic          accept, is_sof, is_eof, last_rd;

  assign accept  = in_valid_i && (state_q != ST_REL);
  assign is_sof  = in_data_i == SOF;
  assign is_eof  = in_data_i == EOF;
  assign last_rd = {1'b0, rd_q} == (len_q - 1'b1);

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    rd_d      = rd_q;
    wr_en_o   = 1'b0;
    wr_addr_o = '0;
    drop_o    = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (accept && is_sof) begin
          wr_en_o = 1'b1;
          len_d   = LW'(1);
          state_d = ST_COLL;
        end
      end
      ST_COLL: begin
        if (accept) begin
          if (is_sof) begin
            // restart on the new start marker
            drop_o  = 1'b1;
            wr_en_o = 1'b1;
            len_d   = LW'(1);
          end else if (len_q == LEN_MAX) begin
            drop_o  = 1'b1;
            state_d = ST_HUNT;
          end else begin
            wr_en_o   = 1'b1;
            wr_addr_o = len_q[AW-1:0];
            len_d     = len_q + 1'b1;
            if (is_eof) begin
              rd_d    = '0;
              state_d = ST_REL;
            end
          end
        end
      end
      ST_REL: begin
        if (out_ready_i) begin
          if (last_rd) state_d = ST_HUNT;
          else         rd_d    = rd_q + 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      len_q   <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      rd_q    <= rd_d;
    end
  end

  assign in_ready_o  = state_q != ST_REL;
  assign out_valid_o = state_q == ST_REL;
  assign out_last_o  = out_valid_o && last_rd;
  assign in_packet_o = state_q == ST_COLL;
  assign rd_addr_o   = rd_q;

  // R3
  open_on_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_packet_o) |-> $past(in_valid_i && in_data_i == SOF));
  // R7
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_MAX);
  // R4
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o && out_ready_i) |=> !out_valid_o);
  // R5
  release_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_data_i == EOF));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int         DEPTH = 512,
  parameter int         CNT_W = 8,
  parameter logic [7:0] SOF   = 8'hFF,
  parameter logic [7:0] EOF   = 8'hFE,
  localparam int        AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic             in_packet_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  logic          wr_en, drop;
  logic [AW-1:0] wr_addr, rd_addr;

  framer_ctrl #(.DEPTH(DEPTH), .SOF(SOF), .EOF(EOF)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i),
    .in_packet_o (in_packet_o),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_addr_o   (rd_addr),
    .drop_o      (drop)
  );

  pkt_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (in_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (out_data_o)
  );

  drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop),
    .cnt_o  (drop_cnt_o)
  );

  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
  // R8
  no_in_during_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
endmodule

// File: tb/pkt_framer_test.sv
module pkt_framer_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, in_packet;
  logic [7:0] out_data;
  logic [CNT_W-1:0] drop_cnt;

  int total = 0, bad = 0, cyc = 0;
  bit hold_low = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pkt_framer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_last_o(out_last), .out_ready_i(out_ready), .in_packet_o(in_packet),
    .drop_cnt_o(drop_cnt)
  );

  // reference model: 0 hunt, 1 collect, 2 release
  int m_mode = 0, m_rd = 0, m_drops = 0;
  logic [7:0] m_pkt[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rd = 0; m_drops = 0; m_pkt.delete();
    end else if (m_mode == 2) begin
      if (out_ready) begin
        if (m_rd == m_pkt.size() - 1) m_mode = 0;
        else m_rd++;
      end
    end else if (in_valid) begin
      if (m_mode == 0) begin
        if (in_data == 8'hFF) begin m_pkt = {in_data}; m_mode = 1; end
      end else if (in_data == 8'hFF) begin
        if (m_drops < 255) m_drops++;
        m_pkt = {in_data};
      end else if (m_pkt.size() == DEPTH) begin
        if (m_drops < 255) m_drops++;
        m_mode = 0;
      end else begin
        m_pkt.push_back(in_data);
        if (in_data == 8'hFE) begin m_mode = 2; m_rd = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == (m_mode == 2), "R5 out_valid", out_valid, m_mode == 2);
      check(in_ready == (m_mode != 2), "R8 in_ready", in_ready, m_mode != 2);
      check(in_packet == (m_mode == 1), "R10 in_packet", in_packet, m_mode == 1);
      check(drop_cnt == m_drops, "R9 drop_cnt", drop_cnt, m_drops);
      if (m_mode == 2 && out_valid) begin
        check(out_data == m_pkt[m_rd], "R4 out_data", out_data, m_pkt[m_rd]);
        check(out_last == (m_rd == m_pkt.size() - 1), "R4 out_last", out_last,
              m_rd == m_pkt.size() - 1);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      out_ready = hold_low ? 1'b0 : (cyc % 3 != 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); #1;
    while (!in_ready) begin in_valid = 1'b0; @(negedge clk); #1; end
    in_valid = 1'b1; in_data = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1; in_valid = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && !in_packet && drop_cnt == 0 && in_ready, "R1 reset", {out_valid, in_packet, in_ready}, 3'b001);
    #1 rst_n = 1'b1;
    idle(2);

    // R2 filler and stray end marker ignored
    send(8'h00); send(8'h00); send(8'hFE); send(8'h37);
    idle(3);
    check(!in_packet && !out_valid && drop_cnt == 0, "R2 hunt discard", {in_packet, out_valid}, 0);

    // R3 start marker opens packet
    send(8'hFF);
    idle(0);
    check(in_packet == 1'b1, "R3 open", in_packet, 1);
    send(8'h01); send(8'h02); send(8'h00); send(8'hFE);
    idle(DEPTH * 4);

    // R6 restart mid-packet
    send(8'hFF); send(8'h11); send(8'h22); send(8'hFF);
    idle(0);
    check(drop_cnt == 1 && in_packet, "R6 restart", drop_cnt, 1);
    send(8'h33); send(8'hFE);
    idle(DEPTH * 4);

    // R7 exactly DEPTH bytes passes
    send(8'hFF);
    for (int i = 0; i < DEPTH - 2; i++) send(8'(i + 8'h40));
    send(8'hFE);
    idle(DEPTH * 4);
    check(drop_cnt == 1, "R7 full fits", drop_cnt, 1);

    // R7 one more byte overflows
    send(8'hFF);
    for (int i = 0; i < DEPTH - 1; i++) send(8'(i + 8'h60));
    send(8'h05);
    idle(0);
    check(drop_cnt == 2 && !in_packet, "R7 overflow", drop_cnt, 2);
    send(8'hFE); send(8'h06);
    idle(3);
    check(!out_valid && !in_packet, "R7 tail discarded", out_valid, 0);

    // back-to-back packets, minimum size, then stalled output
    send(8'hFF); send(8'hFE);
    send(8'hFF); send(8'hAA); send(8'hFE);
    idle(0);
    hold_low = 1'b1;
    idle(10);
    check(out_valid && out_data == 8'hFF, "R8 stall hold", out_data, 8'hFF);
    hold_low = 1'b0;
    idle(DEPTH * 4);
    send(8'h00); send(8'hFF); send(8'h7E); send(8'hFE); send(8'h00);
    idle(DEPTH * 4);
    check(drop_cnt == 2 && !out_valid, "R9 final drops", drop_cnt, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule